// File: doc/BRIEF.md
# External Memory Window Error Bridge

This block is an APB completer placed in front of several external memory blocks. Each memory sits in its own address window. A window's base address, its size in words, the access directions it allows and whether it may report errors are all fixed at elaboration. When a transfer lands in a window, the bridge sends that memory one request pulse with a word offset. It keeps PREADY low until the memory acknowledges in the matching direction, then completes the transfer with the returned read data and, where allowed, an error response.

Read errors pass to the bus only for requests the bridge knows are outstanding. Each error-capable window keeps a registered in-flight flag. The request pulse sets the flag, and an acknowledge that the window's access mode counts as finishing clears it. Write errors need no such qualification. Windows that are not error-capable never raise PSLVERR.

Top module: `ext_mem_err_bridge`

## Requirements
- R1: A transfer whose word-aligned PADDR (bits [1:0] zero) lies in [base, base + 4*words) of a window, in a direction that window allows, gives exactly one single-cycle pulse on that window's bit of mem_req, in the first access-phase cycle. The pulse carries mem_word = (PADDR - base) >> 2, mem_write = PWRITE and mem_wdata = PWDATA. Where windows overlap, the lowest index wins.
- R2: For such a transfer, PREADY stays low in the access phase until the selected window's acknowledge for the transfer's direction is high (mem_rd_ack for reads, mem_wr_ack for writes). An acknowledge in the pulse cycle completes the transfer in that cycle. On read completion, PRDATA equals that window's mem_rd_data slice; at all other times it is zero.
- R3: An access to no window, a misaligned address, a read of a write-only window or a write to a read-only window completes in its first access cycle. It gives PRDATA zero, PSLVERR low and no request pulse.
- R4: An error-capable window's in-flight flag is set one cycle after its request pulse. It is cleared one cycle after a finishing acknowledge: mem_rd_ack for read-only windows (mode 1), mem_wr_ack for write-only windows (mode 2), and either for read-write windows (mode 0). When a pulse and a finishing acknowledge coincide, the flag ends cleared. The synchronous reset clears it.
- R5: A read completion raises PSLVERR only if the window is error-capable, its mem_rd_err is high and its in-flight flag is already set in that cycle. A read acknowledged in the pulse cycle therefore never reports an error.
- R6: A write completion to an error-capable window raises PSLVERR whenever its mem_wr_err is high, including when the acknowledge comes in the pulse cycle.
- R7: A window that is not error-capable never raises PSLVERR, whatever its error inputs carry.
- R8: PSLVERR is high only in a cycle where PREADY is high.
- R9: While rst is high and afterwards with PSEL low, PREADY, PSLVERR, PRDATA and mem_req are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB direction, 1 = write |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data |
| pready | output | 1 | APB transfer completion |
| pslverr | output | 1 | APB error response |
| mem_req | output | NW | Per-window one-cycle request pulse |
| mem_write | output | 1 | Request direction, 1 = write |
| mem_word | output | ADDR_W-2 | Word offset inside the window |
| mem_wdata | output | DATA_W | Write data to the memories |
| mem_rd_data | input | NW*DATA_W | Per-window read data, window 0 in the low slice |
| mem_rd_ack | input | NW | Per-window read acknowledge |
| mem_rd_err | input | NW | Per-window read error, valid with mem_rd_ack |
| mem_wr_ack | input | NW | Per-window write acknowledge |
| mem_wr_err | input | NW | Per-window write error, valid with mem_wr_ack |

## Verification
The request pulse and the acknowledge can fall in the same cycle. In that cycle the in-flight flag is still clear, so a read error must be dropped while a write error must still reach PSLVERR. The bench provokes this by raising the acknowledge together with PENABLE at zero latency, and compares this against later acknowledges with the same error input. It also sends an opposite-direction acknowledge in the middle of a read. On a read-write window this clears the flag and must suppress the later read error. On a read-only window it must not. A cycle-accurate model in the bench tracks the flags and judges PSLVERR, PREADY, PRDATA and the request outputs on every cycle.

// File: rtl/ext_win_pkg.sv
package ext_win_pkg;

    localparam logic [1:0] WMODE_RW = 2'd0;
    localparam logic [1:0] WMODE_RO = 2'd1;
    localparam logic [1:0] WMODE_WO = 2'd2;

    typedef struct packed {
        logic issued;
    } bus_state_t;

    function automatic logic ack_finishes(input logic [1:0] mode,
                                          input logic rd_ack,
                                          input logic wr_ack);
        case (mode)
            WMODE_RO: ack_finishes = rd_ack;
            WMODE_WO: ack_finishes = wr_ack;
            default:  ack_finishes = rd_ack | wr_ack;
        endcase
    endfunction

    function automatic logic dir_allowed(input logic [1:0] mode,
                                         input logic is_write);
        case (mode)
            WMODE_RO: dir_allowed = ~is_write;
            WMODE_WO: dir_allowed = is_write;
            default:  dir_allowed = 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/win_decode.sv
module win_decode
    import ext_win_pkg::*;
#(
    parameter int NW     = 4,
    parameter int ADDR_W = 20,
    parameter int IDX_W  = 2,
    parameter logic [NW*ADDR_W-1:0] WIN_BASE  = '0,
    parameter logic [NW*32-1:0]     WIN_WORDS = '0,
    parameter logic [NW*2-1:0]      WIN_MODE  = '0
) (
    input  logic [ADDR_W-1:0] paddr,
    input  logic              pwrite,
    output logic              hit,
    output logic [IDX_W-1:0]  sel,
    output logic              dir_ok,
    output logic [ADDR_W-3:0] word_off
);
    localparam int WADDR_W = ADDR_W - 2;

    logic [NW-1:0]      in_win;
    logic [WADDR_W-1:0] off [NW];
    logic [63:0]        addr_wide;
    logic               aligned;

    assign addr_wide = 64'(paddr);
    assign aligned   = (paddr[1:0] == 2'b00);

    for (genvar i = 0; i < NW; i++) begin : g_win
        localparam logic [ADDR_W-1:0] BASE_I = WIN_BASE[i*ADDR_W +: ADDR_W];
        localparam logic [63:0] LO_I = 64'(BASE_I);
        localparam logic [63:0] HI_I = LO_I + 64'(WIN_WORDS[i*32 +: 32]) * 64'd4;
        assign in_win[i] = aligned && (addr_wide >= LO_I) && (addr_wide < HI_I);
        assign off[i]    = paddr[ADDR_W-1:2] - BASE_I[ADDR_W-1:2];
    end

    always_comb begin
        sel = '0;
        for (int i = NW - 1; i >= 0; i--) begin
            if (in_win[i]) sel = IDX_W'(i);
        end
    end

    assign hit      = |in_win;
    assign dir_ok   = dir_allowed(WIN_MODE[sel*2 +: 2], pwrite);
    assign word_off = off[sel];

endmodule

// File: rtl/win_inflight.sv
module win_inflight
    import ext_win_pkg::*;
#(
    parameter int NW = 4,
    parameter logic [NW*2-1:0] WIN_MODE = '0,
    parameter logic [NW-1:0]   WIN_ERR  = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NW-1:0] strb,
    input  logic [NW-1:0] rd_ack,
    input  logic [NW-1:0] wr_ack,
    output logic [NW-1:0] inflight
);
    typedef struct packed {
        logic [NW-1:0] flag;
    } trk_t;

    trk_t          trk_d, trk_q;
    logic [NW-1:0] clr;

    always_comb begin
        trk_d = trk_q;
        for (int i = 0; i < NW; i++) begin
            clr[i] = ack_finishes(WIN_MODE[i*2 +: 2], rd_ack[i], wr_ack[i]);
            if (!WIN_ERR[i])  trk_d.flag[i] = 1'b0;
            else if (clr[i])  trk_d.flag[i] = 1'b0;
            else if (strb[i]) trk_d.flag[i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) trk_q <= '0;
        else     trk_q <= trk_d;
    end

    assign inflight = trk_q.flag;

    for (genvar i = 0; i < NW; i++) begin : g_chk
        // R4: a finishing ack beats a simultaneous request
        a_r4_clear_wins: assert property (@(posedge clk) disable iff (rst)
            (strb[i] && clr[i]) |=> !inflight[i]);
        // R4: a request with no finishing ack sets the flag of an error-capable window
        a_r4_set_on_req: assert property (@(posedge clk) disable iff (rst)
            (WIN_ERR[i] && strb[i] && !clr[i]) |=> inflight[i]);
        // R4: the flag only rises after a request
        a_r4_rise_cause: assert property (@(posedge clk) disable iff (rst)
            $rose(inflight[i]) |-> $past(strb[i]));
    end

endmodule

// File: rtl/ext_mem_err_bridge.sv
module ext_mem_err_bridge
    import ext_win_pkg::*;
#(
    parameter int NW     = 4,
    parameter int ADDR_W = 20,
    parameter int DATA_W = 32,
    parameter logic [NW*ADDR_W-1:0] WIN_BASE  = {20'h71000, 20'h70000, 20'h60000, 20'h40000},
    parameter logic [NW*32-1:0]     WIN_WORDS = {32'd256, 32'd256, 32'd1024, 32'd32768},
    parameter logic [NW*2-1:0]      WIN_MODE  = {2'd2, 2'd1, 2'd0, 2'd0},
    parameter logic [NW-1:0]        WIN_ERR   = 4'b1101
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 psel,
    input  logic                 penable,
    input  logic                 pwrite,
    input  logic [ADDR_W-1:0]    paddr,
    input  logic [DATA_W-1:0]    pwdata,
    output logic [DATA_W-1:0]    prdata,
    output logic                 pready,
    output logic                 pslverr,
    output logic [NW-1:0]        mem_req,
    output logic                 mem_write,
    output logic [ADDR_W-3:0]    mem_word,
    output logic [DATA_W-1:0]    mem_wdata,
    input  logic [NW*DATA_W-1:0] mem_rd_data,
    input  logic [NW-1:0]        mem_rd_ack,
    input  logic [NW-1:0]        mem_rd_err,
    input  logic [NW-1:0]        mem_wr_ack,
    input  logic [NW-1:0]        mem_wr_err
);
    localparam int IDX_W = (NW > 1) ? $clog2(NW) : 1;

    logic              dec_hit;
    logic [IDX_W-1:0]  dec_sel;
    logic              dec_dir_ok;
    logic [ADDR_W-3:0] dec_word;

    win_decode #(
        .NW(NW), .ADDR_W(ADDR_W), .IDX_W(IDX_W),
        .WIN_BASE(WIN_BASE), .WIN_WORDS(WIN_WORDS), .WIN_MODE(WIN_MODE)
    ) u_dec (
        .paddr(paddr), .pwrite(pwrite),
        .hit(dec_hit), .sel(dec_sel), .dir_ok(dec_dir_ok), .word_off(dec_word)
    );

    bus_state_t        st_d, st_q;
    logic              access, valid, sel_ack, rd_fail, wr_fail;
    logic              ready_c, err_c;
    logic [DATA_W-1:0] rdata_c;
    logic [NW-1:0]     strb;
    logic [NW-1:0]     infl;

    always_comb begin
        st_d    = st_q;
        access  = psel & penable;
        valid   = access & dec_hit & dec_dir_ok;
        strb    = '0;
        if (valid && !st_q.issued) strb[dec_sel] = 1'b1;
        sel_ack = pwrite ? mem_wr_ack[dec_sel] : mem_rd_ack[dec_sel];
        ready_c = access & (~valid | sel_ack);
        rd_fail = mem_rd_ack[dec_sel] & mem_rd_err[dec_sel] & infl[dec_sel];
        wr_fail = mem_wr_ack[dec_sel] & mem_wr_err[dec_sel];
        err_c   = ready_c & valid & WIN_ERR[dec_sel] & (pwrite ? wr_fail : rd_fail);
        rdata_c = (ready_c && valid && !pwrite) ? mem_rd_data[dec_sel*DATA_W +: DATA_W] : '0;
        if (ready_c)    st_d.issued = 1'b0;
        else if (|strb) st_d.issued = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    win_inflight #(
        .NW(NW), .WIN_MODE(WIN_MODE), .WIN_ERR(WIN_ERR)
    ) u_trk (
        .clk(clk), .rst(rst), .strb(strb),
        .rd_ack(mem_rd_ack), .wr_ack(mem_wr_ack), .inflight(infl)
    );

    assign prdata    = rdata_c;
    assign pready    = ready_c;
    assign pslverr   = err_c;
    assign mem_req   = strb;
    assign mem_write = pwrite;
    assign mem_word  = dec_word;
    assign mem_wdata = pwdata;

    // R8: error response only with completion
    a_r8_err_with_ready: assert property (@(posedge clk) disable iff (rst)
        pslverr |-> pready);
    // R1: at most one window requested, never two cycles in a row
    a_r1_onehot_req: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mem_req));
    a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (|mem_req) |=> !(|mem_req));
    // R3: unusable address finishes at once, silently
    a_r3_miss_done: assert property (@(posedge clk) disable iff (rst)
        (psel && penable && !(dec_hit && dec_dir_ok)) |->
        (pready && !pslverr && mem_req == '0 && prdata == '0));
    // R7: plain windows never report
    a_r7_plain_silent: assert property (@(posedge clk) disable iff (rst)
        (psel && penable && dec_hit && !WIN_ERR[dec_sel]) |-> !pslverr);

endmodule

// File: tb/ext_mem_err_bridge_bench.sv
module ext_mem_err_bridge_bench;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [19:0]  paddr = '0;
    logic [31:0]  pwdata = '0;
    logic [31:0]  prdata;
    logic         pready, pslverr;
    logic [3:0]   mem_req;
    logic         mem_write;
    logic [17:0]  mem_word;
    logic [31:0]  mem_wdata;
    logic [127:0] mem_rd_data = '0;
    logic [3:0]   rd_ack = '0, rd_err = '0, wr_ack = '0, wr_err = '0;

    int checks = 0;
    int fails  = 0;

    // model of the window map: 0 read-write, 1 read-only, 2 write-only
    int unsigned m_base [4] = '{32'h40000, 32'h60000, 32'h70000, 32'h71000};
    int unsigned m_words[4] = '{32768, 1024, 256, 256};
    int          m_mode [4] = '{0, 0, 1, 2};
    bit          m_errc [4] = '{1'b1, 1'b0, 1'b1, 1'b1};
    bit          m_infl [4] = '{default: 1'b0};
    bit          m_issued = 1'b0;

    ext_mem_err_bridge u_ext_mem_err_bridge (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .mem_req(mem_req), .mem_write(mem_write),
        .mem_word(mem_word), .mem_wdata(mem_wdata), .mem_rd_data(mem_rd_data),
        .mem_rd_ack(rd_ack), .mem_rd_err(rd_err), .mem_wr_ack(wr_ack),
        .mem_wr_err(wr_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int find_win(input logic [19:0] a);
        for (int i = 0; i < 4; i++) begin
            if (a[1:0] == 2'b00 && a >= m_base[i] && a < m_base[i] + 4 * m_words[i])
                return i;
        end
        return -1;
    endfunction

    // cycle model: evaluated at negedge, state advanced for the next posedge
    always @(negedge clk) begin
        if (rst) begin
            m_infl   = '{default: 1'b0};
            m_issued = 1'b0;
        end else begin
            int   w;
            bit   acc, okdir, valid, ack, e_rdy, e_err;
            logic [3:0]  e_req;
            logic [31:0] e_rd;
            string etag;
            acc   = psel && penable;
            w     = find_win(paddr);
            okdir = (w >= 0) && (m_mode[w] == 0 || (m_mode[w] == 1 && !pwrite) ||
                                 (m_mode[w] == 2 && pwrite));
            valid = acc && okdir;
            e_req = (valid && !m_issued) ? (4'b1 << w) : 4'b0;
            ack   = valid && (pwrite ? wr_ack[w] : rd_ack[w]);
            e_rdy = acc && (!valid || ack);
            e_err = e_rdy && valid && m_errc[w] &&
                    (pwrite ? wr_err[w] : (rd_err[w] && m_infl[w]));
            e_rd  = (e_rdy && valid && !pwrite) ? mem_rd_data[w*32 +: 32] : 32'h0;

            chk(mem_req === e_req, "R1 request pulse", 64'(mem_req), 64'(e_req));
            if (e_req != 0) begin
                chk(mem_word === 18'((paddr - m_base[w]) >> 2), "R1 word offset",
                    64'(mem_word), 64'((paddr - m_base[w]) >> 2));
                chk(mem_write === pwrite && mem_wdata === pwdata, "R1 dir/wdata",
                    64'(mem_wdata), 64'(pwdata));
            end
            chk(pready === e_rdy, valid ? "R2 pready" : "R3 pready",
                64'(pready), 64'(e_rdy));
            chk(prdata === e_rd, valid ? "R2 prdata" : "R3 prdata",
                64'(prdata), 64'(e_rd));
            if (!valid)          etag = "R3 pslverr";
            else if (!m_errc[w]) etag = "R7 pslverr";
            else if (pwrite)     etag = "R6 pslverr";
            else                 etag = "R5 pslverr (R4 inflight)";
            chk(pslverr === e_err, etag, 64'(pslverr), 64'(e_err));
            chk(!(pslverr && !pready), "R8 pslverr without pready",
                64'(pslverr), 64'(0));

            // R4: finishing ack wins over request; only error-capable windows track
            for (int i = 0; i < 4; i++) begin
                bit fin;
                fin = (m_mode[i] == 1) ? rd_ack[i] :
                      (m_mode[i] == 2) ? wr_ack[i] : (rd_ack[i] || wr_ack[i]);
                if (!m_errc[i])    m_infl[i] = 1'b0;
                else if (fin)      m_infl[i] = 1'b0;
                else if (e_req[i]) m_infl[i] = 1'b1;
            end
            if (e_rdy)          m_issued = 1'b0;
            else if (e_req != 0) m_issued = 1'b1;
        end
    end

    // one APB transfer; tgt acks after lat access cycles, stray = opposite-direction ack cycle
    task automatic xfer(input bit wr, input logic [19:0] a, input logic [31:0] wd,
                        input int tgt, input int lat, input bit err,
                        input logic [31:0] rd, input int stray);
        @(posedge clk); #1;
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = wd;
        if (tgt >= 0) mem_rd_data[tgt*32 +: 32] = rd;
        @(posedge clk); #1;
        penable = 1'b1;
        for (int k = 0; k < 30; k++) begin
            rd_ack = '0; wr_ack = '0; rd_err = '0; wr_err = '0;
            if (tgt >= 0 && k == lat) begin
                if (wr) begin wr_ack[tgt] = 1'b1; wr_err[tgt] = err; end
                else    begin rd_ack[tgt] = 1'b1; rd_err[tgt] = err; end
            end
            if (tgt >= 0 && k == stray) begin
                if (wr) rd_ack[tgt] = 1'b1;
                else    wr_ack[tgt] = 1'b1;
            end
            @(negedge clk);
            if (pready) break;
            @(posedge clk); #1;
        end
        @(posedge clk); #1;
        psel = 1'b0; penable = 1'b0;
        rd_ack = '0; wr_ack = '0; rd_err = '0; wr_err = '0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R9: idle outputs after reset
        chk(pready === 1'b0 && pslverr === 1'b0, "R9 idle pready/pslverr",
            64'({pready, pslverr}), 64'(0));
        chk(mem_req === 4'b0 && prdata === 32'h0, "R9 idle req/prdata",
            64'(mem_req), 64'(0));

        // R5/R4: same-cycle ack after reset drops the read error
        xfer(1'b0, 20'h40000, 32'h0, 0, 0, 1'b1, 32'hA5A5_0001, -1);
        // R2/R5: delayed reads, with and without error
        for (int j = 0; j < 4; j++)
            xfer(1'b0, 20'h40000 + 20'(j * 400), 32'h0, 0, j, j[0],
                 32'h1000_0000 + 32'(j), -1);
        // R6: write errors at zero and later latency
        xfer(1'b1, 20'h40010, 32'hDEAD_BEEF, 0, 0, 1'b1, 32'h0, -1);
        xfer(1'b1, 20'h40014, 32'h1234_5678, 0, 3, 1'b1, 32'h0, -1);
        xfer(1'b1, 20'h40018, 32'h0BAD_F00D, 0, 2, 1'b0, 32'h0, -1);
        // R1: window boundaries
        xfer(1'b0, 20'h5FFFC, 32'h0, 0, 1, 1'b0, 32'hCAFE_0002, -1);
        xfer(1'b0, 20'h60000, 32'h0, 1, 1, 1'b0, 32'hCAFE_0003, -1);
        // R7: plain window ignores error inputs
        xfer(1'b0, 20'h60FFC, 32'h0, 1, 2, 1'b1, 32'hCAFE_0004, -1);
        xfer(1'b1, 20'h60100, 32'h5555_AAAA, 1, 0, 1'b1, 32'h0, -1);
        // R4: stray write ack clears read-write flag, not read-only flag
        xfer(1'b0, 20'h40020, 32'h0, 0, 3, 1'b1, 32'hCAFE_0005, 1);
        xfer(1'b0, 20'h70004, 32'h0, 2, 2, 1'b1, 32'hCAFE_0006, 1);
        xfer(1'b0, 20'h70008, 32'h0, 2, 1, 1'b1, 32'hCAFE_0007, -1);
        // R3: wrong direction, unmapped, misaligned
        xfer(1'b1, 20'h70000, 32'h7777_7777, -1, 0, 1'b0, 32'h0, -1);
        xfer(1'b0, 20'h71000, 32'h0, -1, 0, 1'b0, 32'h0, -1);
        xfer(1'b0, 20'h30000, 32'h0, -1, 0, 1'b0, 32'h0, -1);
        xfer(1'b0, 20'h40002, 32'h0, -1, 0, 1'b0, 32'h0, -1);
        // R6: write-only window, flag cleared by write ack
        xfer(1'b1, 20'h71004, 32'h9999_0000, 3, 1, 1'b1, 32'h0, -1);
        xfer(1'b1, 20'h71008, 32'h9999_0001, 3, 0, 1'b0, 32'h0, -1);

        repeat (3) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog expired: actual=hung expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule